// File: doc/BRIEF.md
# Dual-Gain Global Shutter Frame Sequencer

This block drives the control lines that are common to every pixel of a dual-gain, voltage-sampling global shutter array. A trigger starts an exposure whose length is given in milliseconds. When the exposure ends, the block runs the frame-overhead sequence. That sequence samples the reset level and the signal level of the pixel twice, once in each gain, into the in-pixel sample capacitors. A single exposure therefore gives both a low-gain and a high-gain correlated double sampling pair.

Gain is selected by a switch that joins an extra capacitance to the floating diffusion. With the switch open the pixel is in high gain. The first transfer pulse moves charge in high gain. The switch is then closed again, and a second transfer pulse moves any charge that is left, in low gain. Every phase length is set in clock cycles through input ports. A millisecond tick is derived from a clock-frequency parameter. All control outputs come straight from registers.

Top module: `dgs_fot_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, pixel reset is high, the gain switch is closed (`hdr_on_o`=1), and transfer, all four strobes, busy and done are low.
- R2: A trigger accepted while idle raises busy. Pixel reset then stays high for exactly E×(CLK_HZ/1000) cycles, counted from the rise of busy, before it falls. E is the integration time in ms, sampled at the trigger.
- R3: An integration time of 0 is taken as 1 ms. A value above MAX_MS (default 5000) is taken as MAX_MS.
- R4: The frame-overhead order is fixed: pixel reset falls; R cycles later the low-gain reset strobe starts; the high-gain reset strobe starts S+H cycles after that; the high-gain signal strobe starts T+W cycles after the first transfer rises; the low-gain signal strobe starts T+W cycles after the second transfer rises. R, S, H, T and W are the release, strobe, switch-settle, transfer and settle lengths.
- R5: The gain switch opens S cycles after the low-gain reset strobe starts, so high gain begins as that strobe ends. It closes S cycles after the high-gain signal strobe starts. It stays open for exactly H+2S+T+W cycles. The high-gain strobes occur only while the switch is open, and the low-gain strobes only while it is closed.
- R6: Each frame has exactly two transfer pulses of T cycles each. The first starts S cycles after the high-gain reset strobe starts. The second starts H cycles after the switch closes. The switch never changes while transfer is high.
- R7: Each of the four strobes is one contiguous pulse of exactly S cycles, once per frame.
- R8: A phase length of 0 is taken as 1 cycle.
- R9: At most one of pixel reset, transfer and the four strobes is high in any cycle.
- R10: Pixel reset rises again S cycles after the low-gain signal strobe starts. It stays high through idle and through the next exposure. Busy stays high for exactly E×(CLK_HZ/1000)+R+4S+2H+2T+2W cycles.
- R11: A trigger that arrives while busy is high is ignored: it neither restarts nor lengthens the frame, and it does not add a second frame.
- R12: Done is high for exactly one cycle per frame, in the cycle where busy falls and pixel reset rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame trigger, sampled while idle |
| integ_ms_i | input | MS_W | Integration time in milliseconds |
| t_rel_i | input | PH_W | Cycles from pixel reset release to the first strobe |
| t_smp_i | input | PH_W | Length of every sample strobe |
| t_hdr_i | input | PH_W | Settle cycles after each switch change |
| t_tx_i | input | PH_W | Length of each transfer pulse |
| t_set_i | input | PH_W | Settle cycles after each transfer pulse |
| pix_rst_o | output | 1 | Global pixel (floating diffusion) reset |
| hdr_on_o | output | 1 | Extra capacitance joined (1 = low gain) |
| tx_o | output | 1 | Global transfer gate |
| smp_lr_o | output | 1 | Low-gain reset sample strobe |
| smp_hr_o | output | 1 | High-gain reset sample strobe |
| smp_hs_o | output | 1 | High-gain signal sample strobe |
| smp_ls_o | output | 1 | Low-gain signal sample strobe |
| busy_o | output | 1 | Exposure or frame overhead in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest cases to reach from the ports are the exposure bounds. A 5000 ms exposure counted in real milliseconds would take far too long. The bench therefore sets the clock-frequency parameter so that one millisecond is only four cycles, which puts both clamps within reach. A second hard case is a trigger that lands in the middle of a running exposure. The bench fires it a few cycles after busy rises, then checks that the frame keeps its length and that only one done pulse appears. Every phase spacing is measured from the edge timestamps of the outputs, for several sets of lengths, including a set where every length is zero.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EXPO,
    ST_REL,
    ST_SLR,
    ST_HOPEN,
    ST_SHR,
    ST_TX1,
    ST_SET1,
    ST_SHS,
    ST_HCLOSE,
    ST_TX2,
    ST_SET2,
    ST_SLS,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic pix_rst;
    logic hdr_on;
    logic tx;
    logic smp_lr;
    logic smp_hr;
    logic smp_hs;
    logic smp_ls;
    logic busy;
    logic done;
  } ctl_t;

  function automatic seq_st_e next_phase(seq_st_e s);
    case (s)
      ST_REL:    return ST_SLR;
      ST_SLR:    return ST_HOPEN;
      ST_HOPEN:  return ST_SHR;
      ST_SHR:    return ST_TX1;
      ST_TX1:    return ST_SET1;
      ST_SET1:   return ST_SHS;
      ST_SHS:    return ST_HCLOSE;
      ST_HCLOSE: return ST_TX2;
      ST_TX2:    return ST_SET2;
      ST_SET2:   return ST_SLS;
      ST_SLS:    return ST_DONE;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic ctl_t decode_st(seq_st_e s);
    ctl_t c;
    c         = '0;
    c.pix_rst = (s == ST_IDLE) || (s == ST_EXPO) || (s == ST_DONE);
    c.hdr_on  = !((s == ST_HOPEN) || (s == ST_SHR) || (s == ST_TX1) ||
                  (s == ST_SET1) || (s == ST_SHS));
    c.tx      = (s == ST_TX1) || (s == ST_TX2);
    c.smp_lr  = (s == ST_SLR);
    c.smp_hr  = (s == ST_SHR);
    c.smp_hs  = (s == ST_SHS);
    c.smp_ls  = (s == ST_SLS);
    c.busy    = (s != ST_IDLE) && (s != ST_DONE);
    c.done    = (s == ST_DONE);
    return c;
  endfunction

endpackage

// File: rtl/dgs_expo_timer.sv
module dgs_expo_timer #(
  parameter int MS_DIV = 50000,
  parameter int MS_W   = 13,
  parameter int MAX_MS = 5000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            run_i,
  output logic            expire_o
);

  localparam int PRE_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  left_q;
  logic [MS_W-1:0]  ms_eff;
  logic             tick;

  always_comb begin
    if (ms_i == '0)                 ms_eff = MS_W'(1);
    else if (ms_i > MS_W'(MAX_MS))  ms_eff = MS_W'(MAX_MS);
    else                            ms_eff = ms_i;
  end

  assign tick     = run_i && (pre_q == PRE_LAST);
  assign expire_o = tick && (left_q == MS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      pre_q  <= '0;
      left_q <= ms_eff;
    end else if (run_i) begin
      if (tick) begin
        pre_q  <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dgs_phase_fsm.sv
module dgs_phase_fsm
  import dgs_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            expire_i,
  input  logic [PH_W-1:0] t_rel_i,
  input  logic [PH_W-1:0] t_smp_i,
  input  logic [PH_W-1:0] t_hdr_i,
  input  logic [PH_W-1:0] t_tx_i,
  input  logic [PH_W-1:0] t_set_i,
  output seq_st_e         st_o,
  output logic            load_o
);

  seq_st_e         st_q;
  seq_st_e         nxt;
  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] raw_len;
  logic [PH_W-1:0] nxt_len;

  assign nxt = (st_q == ST_EXPO) ? ST_REL : next_phase(st_q);

  always_comb begin
    case (nxt)
      ST_REL:                         raw_len = t_rel_i;
      ST_SLR, ST_SHR, ST_SHS, ST_SLS: raw_len = t_smp_i;
      ST_HOPEN, ST_HCLOSE:            raw_len = t_hdr_i;
      ST_TX1, ST_TX2:                 raw_len = t_tx_i;
      ST_SET1, ST_SET2:               raw_len = t_set_i;
      default:                        raw_len = PH_W'(1);
    endcase
    nxt_len = (raw_len == '0) ? PH_W'(1) : raw_len;
  end

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign st_o   = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_EXPO;
        ST_EXPO: begin
          if (expire_i) begin
            st_q  <= nxt;
            cnt_q <= nxt_len - 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: begin
          if (cnt_q == '0) begin
            st_q  <= nxt;
            cnt_q <= nxt_len - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dgs_ctl_reg.sv
module dgs_ctl_reg
  import dgs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  seq_st_e st_i,
  output ctl_t    q_o
);

  ctl_t rst_val;

  always_comb begin
    rst_val         = '0;
    rst_val.pix_rst = 1'b1;
    rst_val.hdr_on  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= rst_val;
    else     q_o <= decode_st(st_i);
  end

endmodule

// File: rtl/dgs_fot_sequencer.sv
module dgs_fot_sequencer
  import dgs_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int MS_W   = 13,
  parameter int PH_W   = 8,
  parameter int MAX_MS = 5000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [MS_W-1:0] integ_ms_i,
  input  logic [PH_W-1:0] t_rel_i,
  input  logic [PH_W-1:0] t_smp_i,
  input  logic [PH_W-1:0] t_hdr_i,
  input  logic [PH_W-1:0] t_tx_i,
  input  logic [PH_W-1:0] t_set_i,
  output logic            pix_rst_o,
  output logic            hdr_on_o,
  output logic            tx_o,
  output logic            smp_lr_o,
  output logic            smp_hr_o,
  output logic            smp_hs_o,
  output logic            smp_ls_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam int MS_DIV = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  seq_st_e st;
  logic    load;
  logic    expire;
  ctl_t    ctl;

  dgs_expo_timer #(
    .MS_DIV (MS_DIV),
    .MS_W   (MS_W),
    .MAX_MS (MAX_MS)
  ) u_expo (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .ms_i     (integ_ms_i),
    .run_i    (st == ST_EXPO),
    .expire_o (expire)
  );

  dgs_phase_fsm #(
    .PH_W (PH_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .expire_i (expire),
    .t_rel_i  (t_rel_i),
    .t_smp_i  (t_smp_i),
    .t_hdr_i  (t_hdr_i),
    .t_tx_i   (t_tx_i),
    .t_set_i  (t_set_i),
    .st_o     (st),
    .load_o   (load)
  );

  dgs_ctl_reg u_out (
    .clk  (clk),
    .rst  (rst),
    .st_i (st),
    .q_o  (ctl)
  );

  assign pix_rst_o = ctl.pix_rst;
  assign hdr_on_o  = ctl.hdr_on;
  assign tx_o      = ctl.tx;
  assign smp_lr_o  = ctl.smp_lr;
  assign smp_hr_o  = ctl.smp_hr;
  assign smp_hs_o  = ctl.smp_hs;
  assign smp_ls_o  = ctl.smp_ls;
  assign busy_o    = ctl.busy;
  assign done_o    = ctl.done;

endmodule

// File: rtl/dgs_seq_chk.sv
module dgs_seq_chk (
  input logic clk,
  input logic rst,
  input logic pix_rst_o,
  input logic hdr_on_o,
  input logic tx_o,
  input logic smp_lr_o,
  input logic smp_hr_o,
  input logic smp_hs_o,
  input logic smp_ls_o,
  input logic busy_o,
  input logic done_o
);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({pix_rst_o, tx_o, smp_lr_o, smp_hr_o, smp_hs_o, smp_ls_o}) <= 1);

  assert_done_width_R12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_at_end_R12: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o && pix_rst_o));

  assert_reset_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> pix_rst_o);

  assert_switch_steady_tx_R6: assert property (@(posedge clk) disable iff (rst)
    tx_o |-> $stable(hdr_on_o));

  assert_high_gain_strobes_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_hr_o || smp_hs_o) |-> !hdr_on_o);

  assert_low_gain_strobes_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_lr_o || smp_ls_o) |-> hdr_on_o);

endmodule

bind dgs_fot_sequencer dgs_seq_chk u_chk (.*);

// File: tb/sim_dgs_fot_sequencer.sv
module sim_dgs_fot_sequencer;

  localparam int CPM = 4;

  typedef struct packed {
    logic [12:0] ms;
    logic [7:0]  r;
    logic [7:0]  s;
    logic [7:0]  h;
    logic [7:0]  t;
    logic [7:0]  w;
    logic        trig;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{13'd2, 8'd3, 8'd2, 8'd2, 8'd3, 8'd2, 1'b0},
    '{13'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 1'b1},
    '{13'd0, 8'd5, 8'd4, 8'd1, 8'd2, 8'd6, 1'b0},
    '{13'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1},
    '{13'd1, 8'd1, 8'd7, 8'd3, 8'd1, 8'd1, 1'b0},
    '{13'd2, 8'd2, 8'd3, 8'd4, 8'd5, 8'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [12:0] integ_ms = '0;
  logic [7:0] t_rel = 8'd1, t_smp = 8'd1, t_hdr = 8'd1, t_tx = 8'd1, t_set = 8'd1;
  logic pix_rst, hdr_on, tx, s_lr, s_hr, s_hs, s_ls, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int busy_rise, busy_fall, busy_nr, busy_hi;
  int prst_fall, prst_rise, hdr_fall, hdr_rise, hdr_lo;
  int tx_r1, tx_r2, tx_nr, tx_hi;
  int done_t, done_nr, overlap;
  int smp_rise [4];
  int smp_nr [4];
  int smp_hi [4];

  always #10 clk = ~clk;

  dgs_fot_sequencer #(.CLK_HZ(CPM * 1000)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .integ_ms_i(integ_ms),
    .t_rel_i(t_rel), .t_smp_i(t_smp), .t_hdr_i(t_hdr), .t_tx_i(t_tx), .t_set_i(t_set),
    .pix_rst_o(pix_rst), .hdr_on_o(hdr_on), .tx_o(tx),
    .smp_lr_o(s_lr), .smp_hr_o(s_hr), .smp_hs_o(s_hs), .smp_ls_o(s_ls),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic run_frame(input vec_t v);
    logic pb, pp, ph, pt, pd;
    logic [3:0] ps, sm;
    integer last;
    busy_rise = -1; busy_fall = -1; busy_nr = 0; busy_hi = 0;
    prst_fall = -1; prst_rise = -1; hdr_fall = -1; hdr_rise = -1; hdr_lo = 0;
    tx_r1 = -1; tx_r2 = -1; tx_nr = 0; tx_hi = 0;
    done_t = -1; done_nr = 0; overlap = 0;
    for (int k = 0; k < 4; k++) begin
      smp_rise[k] = -1; smp_nr[k] = 0; smp_hi[k] = 0;
    end
    @(negedge clk);
    integ_ms = v.ms; t_rel = v.r; t_smp = v.s; t_hdr = v.h; t_tx = v.t; t_set = v.w;
    start = 1'b1;
    pb = busy; pp = pix_rst; ph = hdr_on; pt = tx; pd = done;
    ps = {s_ls, s_hs, s_hr, s_lr};
    last = 30000;
    for (int i = 1; i < 30000 && i < last; i++) begin
      @(negedge clk);
      start = (v.trig && (i == 5)) ? 1'b1 : 1'b0;
      sm = {s_ls, s_hs, s_hr, s_lr};
      if (busy && !pb) begin busy_rise = i; busy_nr++; end
      if (!busy && pb) busy_fall = i;
      if (busy) busy_hi++;
      if (!pix_rst && pp) prst_fall = i;
      if (pix_rst && !pp) prst_rise = i;
      if (!hdr_on && ph) hdr_fall = i;
      if (hdr_on && !ph) hdr_rise = i;
      if (!hdr_on) hdr_lo++;
      if (tx && !pt) begin
        if (tx_nr == 0) tx_r1 = i; else tx_r2 = i;
        tx_nr++;
      end
      if (tx) tx_hi++;
      if (done) begin
        done_nr++;
        if (!pd) begin done_t = i; last = i + 4; end
      end
      for (int k = 0; k < 4; k++) begin
        if (sm[k] && !ps[k]) begin
          if (smp_nr[k] == 0) smp_rise[k] = i;
          smp_nr[k]++;
        end
        if (sm[k]) smp_hi[k]++;
      end
      if ($countones({pix_rst, tx, sm}) > 1) overlap++;
      pb = busy; pp = pix_rst; ph = hdr_on; pt = tx; pd = done; ps = sm;
    end
    start = 1'b0;
  endtask

  initial begin
    int e, r, s, h, t, w, tot;
    string tg;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check_eq("R1 pix_rst in reset", pix_rst, 1);
    check_eq("R1 hdr_on in reset", hdr_on, 1);
    check_eq("R1 strobes/tx in reset", {28'd0, tx, s_lr, s_hr, s_hs} | {31'd0, s_ls}, 0);
    check_eq("R1 busy/done in reset", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 pix_rst after reset", pix_rst, 1);
    check_eq("R1 busy after reset", busy, 0);

    // R10: no trigger keeps the array in reset and idle
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || !pix_rst || tx) begin
        check_eq("R10 idle without trigger", {busy, pix_rst, tx}, 3'b010);
        break;
      end
    end
    check_eq("R10 idle state", {busy, pix_rst}, 2'b01);

    foreach (VECS[n]) begin
      run_frame(VECS[n]);
      e = (VECS[n].ms == 0) ? 1 : ((VECS[n].ms > 5000) ? 5000 : int'(VECS[n].ms));
      r = eff(VECS[n].r); s = eff(VECS[n].s); h = eff(VECS[n].h);
      t = eff(VECS[n].t); w = eff(VECS[n].w);
      tot = e * CPM + r + 4 * s + 2 * h + 2 * t + 2 * w;
      tg = (VECS[n].ms == 0) ? "R3 zero ms clamp" : "R2 exposure length";
      check_eq(tg, prst_fall - busy_rise, e * CPM);
      tg = (VECS[n].r == 0) ? "R8 zero lengths busy" : "R10 busy length";
      check_eq(tg, busy_hi, tot);
      check_eq("R4 release to low-gain reset strobe", smp_rise[0] - prst_fall, r);
      check_eq("R4 low-gain to high-gain reset strobe", smp_rise[1] - smp_rise[0], s + h);
      check_eq("R4 transfer1 to high-gain signal strobe", smp_rise[2] - tx_r1, t + w);
      check_eq("R4 transfer2 to low-gain signal strobe", smp_rise[3] - tx_r2, t + w);
      check_eq("R5 switch opens", hdr_fall - smp_rise[0], s);
      check_eq("R5 switch closes", hdr_rise - smp_rise[2], s);
      check_eq("R5 switch open time", hdr_lo, h + 2 * s + t + w);
      check_eq("R6 transfer count", tx_nr, 2);
      check_eq("R6 transfer high cycles", tx_hi, 2 * t);
      check_eq("R6 first transfer start", tx_r1 - smp_rise[1], s);
      check_eq("R6 second transfer start", tx_r2 - hdr_rise, h);
      for (int k = 0; k < 4; k++) begin
        check_eq("R7 strobe pulse count", smp_nr[k], 1);
        check_eq("R7 strobe width", smp_hi[k], s);
      end
      check_eq("R9 overlap cycles", overlap, 0);
      check_eq("R10 reset rises after last strobe", prst_rise - smp_rise[3], s);
      if (VECS[n].trig) check_eq("R11 busy rises once with extra trigger", busy_nr, 1);
      check_eq("R12 done pulse cycles", done_nr, 1);
      check_eq("R12 done with busy fall", done_t - busy_fall, 0);
      check_eq("R12 done with reset rise", done_t - prst_rise, 0);
    end

    // R3: upper clamp of the integration time
    run_frame('{13'd6000, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 1'b0});
    check_eq("R3 upper ms clamp", prst_fall - busy_rise, 5000 * CPM);
    check_eq("R12 done after long exposure", done_nr, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule